// File: doc/BRIEF.md
# Interrupt Pin Dispatch Unit

This block sits between a bank of level-style interrupt input pins and the processor-local interrupt units of a multi-processor system. Each pin has a redirection entry, held in a register bank outside this block and presented as a flat input word. When a pin goes from low to high, the unit reads that line's entry and turns it into one or more delivery messages on a valid/ready output stream. Each message carries a target ID, a vector, the delivery mode, the destination mode, a level bit and a trigger bit.

Targets are resolved in one of two ways. In physical mode a destination of 0xFF reaches every processor, and any other value addresses a single ID. In logical mode each processor's logical destination byte is matched against the entry destination. Lowest-priority delivery does not compare priorities. It takes one of the logically matched processors, chosen by a free-running rotating offset.

ExtInt entries fetch their vector from an external legacy controller through a request/acknowledge handshake. Pending rising edges from several lines are served one line at a time.

Top module: `pin_dispatch_unit`

## Requirements
- R1: A line is dispatched once for each low-to-high transition of its pin, judged against a stored copy of the pin. Holding the pin high starts no further dispatch, and lowering it sends nothing.
- R2: A line whose entry mask bit (bit 14) is set when the line is taken is dropped, with no message and no error.
- R3: For delivery mode 7 (ExtInt) the unit raises ext_req_o and holds it until ext_ack_i is seen at a clock edge. The message vector is ext_vec_i sampled at that edge. For every other mode the vector is entry bits [7:0].
- R4: Entry word layout per line: vector [7:0], delivery mode [10:8] (1 = lowest priority, 7 = ExtInt), destination mode [11] (1 = logical), polarity [12], trigger [13], mask [14], destination [22:15]. Every message copies delivery mode, destination mode, polarity (as msg_level_o) and trigger from the entry.
- R5: Physical mode with a destination other than 0xFF and a mode other than lowest priority sends exactly one message, whose target is the destination byte.
- R6: Physical mode with destination 0xFF sends one message per processor, with target equal to the processor index, in ascending index order.
- R7: Logical mode with a mode other than lowest priority sends one message to each processor i whose logical byte ANDed with the destination is nonzero. The target is that processor's ID from cpu_id_i, and messages go out in ascending i. With no match, nothing is sent.
- R8: Lowest priority in logical mode with at least one match sends one message, to the k-th match in ascending order, where k = offset mod match count. The 8-bit offset is zero after reset and advances by one on each such dispatch.
- R9: Lowest priority in physical mode raises err_o for exactly one cycle and sends no message.
- R10: Lines pending together are served lowest line number first. While msg_valid_o is high and msg_ready_i is low, the message holds unchanged. A multi-target dispatch emits one message per accepted cycle.
- R11: After reset, msg_valid_o, ext_req_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_LINES | Interrupt input pins |
| rte_i | input | NUM_LINES*23 | Redirection entry per line, line 0 in the lowest bits |
| cpu_ldr_i | input | NUM_CPUS*8 | Logical destination byte per processor |
| cpu_id_i | input | NUM_CPUS*8 | Initial ID per processor |
| ext_req_o | output | 1 | Vector request to the legacy controller |
| ext_ack_i | input | 1 | Vector acknowledge from the legacy controller |
| ext_vec_i | input | 8 | Vector supplied with the acknowledge |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the sink |
| msg_target_o | output | 8 | Target ID |
| msg_vector_o | output | 8 | Vector |
| msg_dmode_o | output | 3 | Delivery mode |
| msg_logical_o | output | 1 | Destination mode, 1 = logical |
| msg_level_o | output | 1 | Level bit (entry polarity) |
| msg_trigger_o | output | 1 | Trigger mode |
| err_o | output | 1 | One-cycle pulse on lowest priority in physical mode |

## Verification
Each kind of corrupted internal state shows at the ports within one dispatch.

- A stale stored pin copy shows up as a duplicated dispatch or a missing one in the next message window.
- A wrong rotating offset picks the wrong lowest-priority processor on the very next such dispatch. The bench repeats lowest-priority dispatches so that the rotation sequence is compared step by step.
- A wrong target set adds, drops or reorders messages within a single broadcast or logical dispatch.
- A latched vector or entry that goes bad shows in the message fields before the sink accepts the message.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

   localparam int          ENTRY_W   = 23;
   localparam logic [2:0]  DM_LOWEST = 3'd1;
   localparam logic [2:0]  DM_EXTINT = 3'd7;
   localparam logic [7:0]  DEST_ALL  = 8'hFF;

   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       trigger;
      logic       polarity;
      logic       logical;
      logic [2:0] dmode;
      logic [7:0] vector;
   } rte_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RESOLVE,
      ST_FETCH,
      ST_SEND
   } pdu_state_t;

endpackage

// File: rtl/pdu_edge_capture.sv
module pdu_edge_capture #(
   parameter int NUM_LINES = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic level_q;
      logic pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            level_q <= 1'b0;
            pend_q  <= 1'b0;
         end else begin
            level_q <= pin_i[g];
            if (pin_i[g] && !level_q)
               pend_q <= 1'b1;
            else if (clr_i[g])
               pend_q <= 1'b0;
         end
      end

      assign pend_o[g] = pend_q;
   end

endmodule

// File: rtl/pdu_line_pick.sv
module pdu_line_pick #(
   parameter int NUM_LINES = 24,
   parameter int LINE_W    = 5
) (
   input  logic [NUM_LINES-1:0] pend_i,
   output logic                 any_o,
   output logic [LINE_W-1:0]    idx_o,
   output logic [NUM_LINES-1:0] onehot_o
);

   always_comb begin
      idx_o = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (pend_i[i])
            idx_o = LINE_W'(i);
      end
   end

   assign any_o    = |pend_i;
   assign onehot_o = pend_i & (~pend_i + NUM_LINES'(1));

endmodule

// File: rtl/pdu_target_resolve.sv
module pdu_target_resolve
   import pdu_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int OFFS_W   = 8
) (
   input  rte_t                  ent_i,
   input  logic [NUM_CPUS*8-1:0] ldr_i,
   input  logic [OFFS_W-1:0]     offset_i,
   output logic [NUM_CPUS-1:0]   set_o,
   output logic                  unicast_o,
   output logic                  bcast_o,
   output logic                  illegal_o,
   output logic                  rotate_o
);

   localparam int CNT_W = $clog2(NUM_CPUS + 1);

   logic [NUM_CPUS-1:0] match;
   logic [NUM_CPUS-1:0] pick;
   logic [CNT_W-1:0]    cnt;
   logic [OFFS_W-1:0]   sel;
   logic [OFFS_W-1:0]   seen;
   logic                lowest;

   for (genvar g = 0; g < NUM_CPUS; g++) begin : g_match
      assign match[g] = |(ldr_i[g*8 +: 8] & ent_i.dest);
   end

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NUM_CPUS; i++)
         cnt = cnt + CNT_W'(match[i]);
   end

   assign sel = (cnt == '0) ? '0 : (offset_i % OFFS_W'(cnt));

   always_comb begin
      pick = '0;
      seen = '0;
      for (int i = 0; i < NUM_CPUS; i++) begin
         if (match[i]) begin
            if (seen == sel)
               pick[i] = 1'b1;
            seen = seen + OFFS_W'(1);
         end
      end
   end

   assign lowest    = (ent_i.dmode == DM_LOWEST);
   assign illegal_o = !ent_i.logical && lowest;
   assign bcast_o   = !ent_i.logical && (ent_i.dest == DEST_ALL);
   assign unicast_o = !ent_i.logical && !bcast_o && !illegal_o;
   assign rotate_o  = ent_i.logical && lowest && (cnt != '0);

   always_comb begin
      if (ent_i.logical)
         set_o = lowest ? pick : match;
      else if (bcast_o)
         set_o = '1;
      else
         set_o = '0;
   end

endmodule

// File: rtl/pin_dispatch_unit.sv
module pin_dispatch_unit
   import pdu_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int NUM_CPUS  = 4,
   parameter int OFFS_W    = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_LINES-1:0]           pin_i,
   input  logic [NUM_LINES*ENTRY_W-1:0]   rte_i,
   input  logic [NUM_CPUS*8-1:0]          cpu_ldr_i,
   input  logic [NUM_CPUS*8-1:0]          cpu_id_i,
   output logic                           ext_req_o,
   input  logic                           ext_ack_i,
   input  logic [7:0]                     ext_vec_i,
   output logic                           msg_valid_o,
   input  logic                           msg_ready_i,
   output logic [7:0]                     msg_target_o,
   output logic [7:0]                     msg_vector_o,
   output logic [2:0]                     msg_dmode_o,
   output logic                           msg_logical_o,
   output logic                           msg_level_o,
   output logic                           msg_trigger_o,
   output logic                           err_o
);

   localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("pin_dispatch_unit: NUM_CPUS must be 1..8");
   end
   if (NUM_LINES < 1 || NUM_LINES > 255) begin : g_bad_lines
      $error("pin_dispatch_unit: NUM_LINES must be 1..255");
   end
   if (OFFS_W < 4) begin : g_bad_offs
      $error("pin_dispatch_unit: OFFS_W must be at least 4");
   end

   pdu_state_t           state_q;
   rte_t                 ent_q;
   rte_t                 ent_pick;
   logic [7:0]           vec_q;
   logic [NUM_CPUS-1:0]  set_q;
   logic                 unicast_q;
   logic                 bcast_q;
   logic [OFFS_W-1:0]    offset_q;
   logic                 err_q;

   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] clr;
   logic [NUM_LINES-1:0] pick_onehot;
   logic [LINE_W-1:0]    pick_idx;
   logic                 pick_any;

   logic [NUM_CPUS-1:0]  res_set;
   logic                 res_unicast;
   logic                 res_bcast;
   logic                 res_illegal;
   logic                 res_rotate;

   logic [NUM_CPUS-1:0]  low_bit;
   logic [CPU_W-1:0]     cur_idx;
   logic                 last_msg;
   logic                 fire;

   pdu_edge_capture #(
      .NUM_LINES (NUM_LINES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   pdu_line_pick #(
      .NUM_LINES (NUM_LINES),
      .LINE_W    (LINE_W)
   ) u_pick (
      .pend_i   (pend),
      .any_o    (pick_any),
      .idx_o    (pick_idx),
      .onehot_o (pick_onehot)
   );

   pdu_target_resolve #(
      .NUM_CPUS (NUM_CPUS),
      .OFFS_W   (OFFS_W)
   ) u_resolve (
      .ent_i     (ent_q),
      .ldr_i     (cpu_ldr_i),
      .offset_i  (offset_q),
      .set_o     (res_set),
      .unicast_o (res_unicast),
      .bcast_o   (res_bcast),
      .illegal_o (res_illegal),
      .rotate_o  (res_rotate)
   );

   assign ent_pick = rte_i[pick_idx*ENTRY_W +: ENTRY_W];
   assign clr      = (state_q == ST_IDLE) ? pick_onehot : '0;

   assign low_bit  = set_q & (~set_q + NUM_CPUS'(1));

   always_comb begin
      cur_idx = '0;
      for (int i = NUM_CPUS - 1; i >= 0; i--) begin
         if (set_q[i])
            cur_idx = CPU_W'(i);
      end
   end

   assign fire     = (state_q == ST_SEND) && msg_ready_i;
   assign last_msg = unicast_q || ((set_q & ~low_bit) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ent_q     <= '0;
         vec_q     <= '0;
         set_q     <= '0;
         unicast_q <= 1'b0;
         bcast_q   <= 1'b0;
         offset_q  <= '0;
         err_q     <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (pick_any) begin
                  ent_q   <= ent_pick;
                  state_q <= ST_RESOLVE;
               end
            end
            ST_RESOLVE: begin
               if (ent_q.mask) begin
                  state_q <= ST_IDLE;
               end else if (res_illegal) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  set_q     <= res_set;
                  unicast_q <= res_unicast;
                  bcast_q   <= res_bcast;
                  if (res_rotate)
                     offset_q <= offset_q + OFFS_W'(1);
                  if (!res_unicast && (res_set == '0)) begin
                     state_q <= ST_IDLE;
                  end else if (ent_q.dmode == DM_EXTINT) begin
                     state_q <= ST_FETCH;
                  end else begin
                     vec_q   <= ent_q.vector;
                     state_q <= ST_SEND;
                  end
               end
            end
            ST_FETCH: begin
               if (ext_ack_i) begin
                  vec_q   <= ext_vec_i;
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (fire) begin
                  set_q <= set_q & ~low_bit;
                  if (last_msg) begin
                     unicast_q <= 1'b0;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (unicast_q)
         msg_target_o = ent_q.dest;
      else if (bcast_q)
         msg_target_o = 8'(cur_idx);
      else
         msg_target_o = cpu_id_i[cur_idx*8 +: 8];
   end

   assign ext_req_o     = (state_q == ST_FETCH);
   assign msg_valid_o   = (state_q == ST_SEND);
   assign msg_vector_o  = vec_q;
   assign msg_dmode_o   = ent_q.dmode;
   assign msg_logical_o = ent_q.logical;
   assign msg_level_o   = ent_q.polarity;
   assign msg_trigger_o = ent_q.trigger;
   assign err_o         = err_q;

endmodule

// File: rtl/pin_dispatch_unit_chk.sv
module pin_dispatch_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       valid,
   input logic       ready,
   input logic [7:0] target,
   input logic [7:0] vector,
   input logic [2:0] dmode,
   input logic       logical,
   input logic       ext_req,
   input logic       ext_ack,
   input logic       err
);

   AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid); // R10

   AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> $stable(target) && $stable(vector) && $stable(dmode) && $stable(logical)); // R10

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R9

   AST_ERR_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !valid); // R9

   AST_NO_PHYS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !logical |-> dmode != 3'd1); // R9

   AST_REQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req && !ext_ack |=> ext_req); // R3

   AST_REQ_NOT_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> !valid); // R3

endmodule

bind pin_dispatch_unit pin_dispatch_unit_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid   (msg_valid_o),
   .ready   (msg_ready_i),
   .target  (msg_target_o),
   .vector  (msg_vector_o),
   .dmode   (msg_dmode_o),
   .logical (msg_logical_o),
   .ext_req (ext_req_o),
   .ext_ack (ext_ack_i),
   .err     (err_o)
);

// File: tb/pin_dispatch_unit_test.sv
module pin_dispatch_unit_test;
   import pdu_pkg::*;

   localparam int NL   = 8;
   localparam int NC   = 4;
   localparam int CLKP = 10;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NL-1:0]          pins = '0;
   rte_t                   rte [NL];
   logic [NL*ENTRY_W-1:0]  rte_flat;
   logic [NC*8-1:0]        ldr;
   logic [NC*8-1:0]        cid;
   logic                   ext_req;
   logic                   ext_ack = 1'b0;
   logic [7:0]             ext_vec = 8'h00;
   logic                   vld;
   logic                   rdy = 1'b0;
   logic [7:0]             tgt, vec;
   logic [2:0]             dm;
   logic                   lg, lvl, trg, err;

   logic [21:0] got  [$];
   logic [21:0] expq [$];
   int n_chk = 0, n_fail = 0;
   int err_seen = 0, exp_err = 0;
   int off_m = 0;
   int unsigned seed_init;

   always #(CLKP/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NL; i++) rte_flat[i*ENTRY_W +: ENTRY_W] = rte[i];
   end

   assign ldr = {8'h0C, 8'h04, 8'h03, 8'h01};
   assign cid = {8'h23, 8'h22, 8'h21, 8'h20};

   pin_dispatch_unit #(.NUM_LINES(NL), .NUM_CPUS(NC), .OFFS_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .rte_i(rte_flat),
      .cpu_ldr_i(ldr), .cpu_id_i(cid),
      .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_vec_i(ext_vec),
      .msg_valid_o(vld), .msg_ready_i(rdy), .msg_target_o(tgt),
      .msg_vector_o(vec), .msg_dmode_o(dm), .msg_logical_o(lg),
      .msg_level_o(lvl), .msg_trigger_o(trg), .err_o(err)
   );

   // sink and legacy controller responders, driven after the edge
   initial begin
      seed_init = $urandom(32'd4711);
      forever begin
         @(posedge clk);
         #1;
         rdy     = ($urandom % 4) != 0;
         ext_ack = ext_req && (($urandom % 3) == 0);
      end
   end

   // monitor: values seen at negedge are the ones taken at the next posedge
   always @(negedge clk) begin
      if (rst_n && vld && rdy) got.push_back({tgt, vec, dm, lg, lvl, trg});
      if (rst_n && err) err_seen++;
   end

   initial begin
      #(CLKP * 200000);
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_exp(logic [7:0] t, logic [7:0] v, rte_t e);
      expq.push_back({t, v, e.dmode, e.logical, e.polarity, e.trigger});
   endtask

   task automatic model_line(int l);
      rte_t e;
      logic [7:0] v;
      int cnt, k, seen;
      e = rte[l];
      if (e.mask) return;
      if (!e.logical && e.dmode == DM_LOWEST) begin exp_err++; return; end
      v = (e.dmode == DM_EXTINT) ? ext_vec : e.vector;
      if (!e.logical) begin
         if (e.dest == 8'hFF) begin
            for (int i = 0; i < NC; i++) push_exp(8'(i), v, e);
         end else push_exp(e.dest, v, e);
      end else begin
         cnt = 0;
         for (int i = 0; i < NC; i++) if ((ldr[i*8 +: 8] & e.dest) != 0) cnt++;
         if (e.dmode == DM_LOWEST) begin
            if (cnt > 0) begin
               k = (off_m % 256) % cnt;
               seen = 0;
               for (int i = 0; i < NC; i++) begin
                  if ((ldr[i*8 +: 8] & e.dest) != 0) begin
                     if (seen == k) push_exp(cid[i*8 +: 8], v, e);
                     seen++;
                  end
               end
               off_m++;
            end
         end else begin
            for (int i = 0; i < NC; i++)
               if ((ldr[i*8 +: 8] & e.dest) != 0) push_exp(cid[i*8 +: 8], v, e);
         end
      end
   endtask

   task automatic compare(string req);
      int n;
      check(req, "message count", 32'(got.size()), 32'(expq.size()));
      n = (got.size() < expq.size()) ? got.size() : expq.size();
      for (int i = 0; i < n; i++) check(req, "message", 32'(got[i]), 32'(expq[i]));
      check(req, "error pulses", 32'(err_seen), 32'(exp_err));
      got.delete(); expq.delete();
      err_seen = 0; exp_err = 0;
   endtask

   task automatic settle();
      repeat (300) @(negedge clk);
   endtask

   task automatic fire(logic [NL-1:0] rise, string req);
      @(negedge clk);
      pins = pins | rise;
      for (int i = 0; i < NL; i++) if (rise[i]) model_line(i);
      settle();
      compare(req);
   endtask

   function automatic rte_t mk(logic [7:0] d, logic lgc, logic [2:0] m, logic [7:0] v,
                               logic msk, logic pol, logic tr);
      rte_t e;
      e.dest = d; e.mask = msk; e.trigger = tr; e.polarity = pol;
      e.logical = lgc; e.dmode = m; e.vector = v;
      return e;
   endfunction

   initial begin
      for (int i = 0; i < NL; i++) rte[i] = mk(8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      // R11 reset state
      check("R11", "valid after reset", 32'(vld), 0);
      check("R11", "ext_req after reset", 32'(ext_req), 0);
      check("R11", "err after reset", 32'(err), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R5 R4 physical unicast, fields copied
      rte[2] = mk(8'h35, 1'b0, 3'd0, 8'h41, 1'b0, 1'b1, 1'b1);
      fire(8'h04, "R5");
      // R1 holding high and lowering send nothing
      repeat (20) @(negedge clk);
      compare("R1");
      pins[2] = 1'b0;
      settle();
      compare("R1");
      // R1 second rising edge dispatches again
      fire(8'h04, "R1");
      pins = '0;

      // R2 masked line
      rte[3] = mk(8'h10, 1'b0, 3'd0, 8'h50, 1'b1, 1'b0, 1'b0);
      fire(8'h08, "R2");
      pins = '0;

      // R6 physical broadcast
      rte[4] = mk(8'hFF, 1'b0, 3'd2, 8'h66, 1'b0, 1'b0, 1'b1);
      fire(8'h10, "R6");
      pins = '0;

      // R7 logical fixed: matches cpu2 and cpu3
      rte[5] = mk(8'h04, 1'b1, 3'd0, 8'h77, 1'b0, 1'b1, 1'b0);
      fire(8'h20, "R7");
      pins = '0;
      // R7 logical with no match
      rte[5] = mk(8'h80, 1'b1, 3'd0, 8'h78, 1'b0, 1'b0, 1'b0);
      fire(8'h20, "R7");
      pins = '0;

      // R8 lowest priority rotation over cpu0/cpu1
      rte[6] = mk(8'h01, 1'b1, DM_LOWEST, 8'h88, 1'b0, 1'b0, 1'b0);
      for (int r = 0; r < 5; r++) begin
         fire(8'h40, "R8");
         pins = '0;
         repeat (3) @(negedge clk);
      end

      // R9 lowest priority in physical mode
      rte[7] = mk(8'h21, 1'b0, DM_LOWEST, 8'h99, 1'b0, 1'b0, 1'b0);
      fire(8'h80, "R9");
      pins = '0;

      // R3 ExtInt vector fetched from the legacy controller
      ext_vec = 8'hC3;
      rte[1] = mk(8'h22, 1'b0, DM_EXTINT, 8'h11, 1'b0, 1'b0, 1'b0);
      fire(8'h02, "R3");
      pins = '0;

      // R10 several lines together, served lowest first
      rte[1] = mk(8'h31, 1'b0, 3'd0, 8'hA1, 1'b0, 1'b0, 1'b0);
      rte[3] = mk(8'h33, 1'b0, 3'd0, 8'hA3, 1'b0, 1'b0, 1'b0);
      rte[5] = mk(8'hFF, 1'b0, 3'd0, 8'hA5, 1'b0, 1'b1, 1'b1);
      fire(8'h2A, "R10");
      pins = '0;

      // random mix (R4 R7 R8 R3 R10)
      for (int it = 0; it < 60; it++) begin
         for (int i = 0; i < NL; i++) begin
            logic [2:0] m;
            logic [7:0] d;
            case ($urandom % 4)
               0: m = 3'd0;
               1: m = DM_LOWEST;
               2: m = DM_EXTINT;
               default: m = 3'd3;
            endcase
            case ($urandom % 4)
               0: d = 8'hFF;
               1: d = 8'(1 << ($urandom % 4));
               default: d = 8'($urandom);
            endcase
            rte[i] = mk(d, 1'($urandom), m, 8'($urandom), ($urandom % 5) == 0,
                        1'($urandom), 1'($urandom));
         end
         ext_vec = 8'($urandom);
         pins = '0;
         repeat (4) @(negedge clk);
         fire(NL'($urandom), "R4");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule